// File: doc/BRIEF.md
# Idle Mode Power Controller

This block parks a processor core in a low-power idle state and brings it back. When the instruction stream issues a power-save request, the controller gates the core clock enable. It pulses a watchdog clear and waits in idle with the system and peripheral clocks still running. The low-power oscillator enable stays up while the watchdog or the clock monitor is in use. An enabled interrupt, a device reset or a watchdog time-out ends the idle state. The controller then reopens the core clock and reports where execution resumes: at the instruction after the power-save request, in the interrupt handler, or at the reset vector.

Entry always runs to completion. It takes one gated ENTERING cycle with the watchdog clear pulse, then at least one IDLE cycle. An enabled interrupt seen during the power-save request or the ENTERING cycle is latched. It wakes the core on the first IDLE cycle. All pins are plain level or single-cycle pulse controls. There is no streaming data, so no valid/ready handshake and no back-pressure apply.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset, core_clk_en_o is 1, wdt_clr_o is 0 and resume_vld_o is 0.
- R2: A pwrsave_req_i sampled while running drives core_clk_en_o to 0 and wdt_clr_o to 1 for exactly the next cycle. core_clk_en_o stays 0 in the cycle after that unless a device reset arrived.
- R3: In idle with no wake event, core_clk_en_o stays 0 and resume_vld_o stays 0. resume_vld_o pulses only in the first cycle with core_clk_en_o back at 1.
- R4: In idle, any bit set in both irq_pend_i and irq_en_i makes the next cycle show core_clk_en_o=1, resume_vld_o=1 and resume_sel_o=1 (handler).
- R5: A source that is pending with its enable bit clear does not wake the core.
- R6: A wdt_timeout_i in idle, with no enabled interrupt and no reset, wakes the core in the next cycle with resume_sel_o=0 (next instruction).
- R7: dev_rst_i during ENTERING or idle wakes the core in the next cycle with resume_sel_o=2 (reset vector). It outranks interrupts and time-outs and discards any latched interrupt.
- R8: An enabled interrupt present with the power-save request or in the ENTERING cycle does not stop entry. The wake pulse with resume_sel_o=1 appears three edges after the power-save request.
- R9: When an enabled interrupt and a watchdog time-out arrive together in idle, resume_sel_o is 1.
- R10: lposc_en_o equals wdt_en_i OR clkmon_en_i at all times, including during idle.
- R11: A pwrsave_req_i sampled together with dev_rst_i while running is ignored, and core_clk_en_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, never gated by this block |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| pwrsave_req_i | input | 1 | Power-save request from the instruction stream |
| irq_pend_i | input | NUM_SRC | Per-source interrupt pending flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| wdt_timeout_i | input | 1 | Watchdog time-out event |
| dev_rst_i | input | 1 | Device reset event |
| wdt_en_i | input | 1 | Watchdog enabled |
| clkmon_en_i | input | 1 | Clock-fail monitor enabled |
| core_clk_en_o | output | 1 | Core clock enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear on idle entry |
| lposc_en_o | output | 1 | Low-power oscillator enable |
| resume_vld_o | output | 1 | One-cycle wake pulse |
| resume_sel_o | output | 2 | Resume target: 0 next instruction, 1 handler, 2 reset vector |

## Verification
Every output except lposc_en_o is registered. The response to inputs sampled at one rising edge is visible after that edge. A latched coincident interrupt wakes the core three edges after the power-save request. lposc_en_o follows its inputs in the same cycle. The bench drives each stimulus just after a falling edge and queues the outputs due after the next rising edge. A monitor pops that entry at the following falling edge, so every comparison lands in the cycle where the registered result first appears.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_IDLE  = 2'd2
  } pstate_e;

  typedef enum logic [1:0] {
    RES_NEXT  = 2'd0,
    RES_ISR   = 2'd1,
    RES_RESET = 2'd2
  } resume_e;
endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               irq_any_o
);
  logic [NUM_SRC-1:0] armed;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign armed[g] = pend_i[g] & en_i[g];
  end

  assign irq_any_o = |armed;
endmodule

// File: rtl/idle_resume_arb.sv
module idle_resume_arb
  import idle_pwr_pkg::*;
(
  input  logic    dev_rst_i,
  input  logic    irq_wake_i,
  input  logic    wdt_to_i,
  output logic    wake_o,
  output resume_e sel_o
);
  always_comb begin
    wake_o = dev_rst_i | irq_wake_i | wdt_to_i;
    if (dev_rst_i)       sel_o = RES_RESET;
    else if (irq_wake_i) sel_o = RES_ISR;
    else                 sel_o = RES_NEXT;
  end
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
  import idle_pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwrsave_req_i,
  input  logic    irq_any_i,
  input  logic    dev_rst_i,
  input  logic    wake_i,
  input  resume_e wake_sel_i,
  output logic    held_o,
  output logic    core_clk_en_o,
  output logic    wdt_clr_o,
  output logic    resume_vld_o,
  output resume_e resume_sel_o
);
  pstate_e state_q;
  logic    held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      held_q       <= 1'b0;
      wdt_clr_o    <= 1'b0;
      resume_vld_o <= 1'b0;
      resume_sel_o <= RES_NEXT;
    end else begin
      wdt_clr_o    <= 1'b0;
      resume_vld_o <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (pwrsave_req_i && !dev_rst_i) begin
            state_q   <= ST_ENTER;
            wdt_clr_o <= 1'b1;
            held_q    <= irq_any_i;
          end
        end
        ST_ENTER: begin
          if (dev_rst_i) begin
            state_q      <= ST_RUN;
            resume_vld_o <= 1'b1;
            resume_sel_o <= RES_RESET;
            held_q       <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            if (irq_any_i) held_q <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (wake_i) begin
            state_q      <= ST_RUN;
            resume_vld_o <= 1'b1;
            resume_sel_o <= wake_sel_i;
            held_q       <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign held_o        = held_q && (state_q == ST_IDLE);
  assign core_clk_en_o = (state_q == ST_RUN);
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pwr_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrsave_req_i,
  input  logic [NUM_SRC-1:0] irq_pend_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               wdt_timeout_i,
  input  logic               dev_rst_i,
  input  logic               wdt_en_i,
  input  logic               clkmon_en_i,
  output logic               core_clk_en_o,
  output logic               wdt_clr_o,
  output logic               lposc_en_o,
  output logic               resume_vld_o,
  output logic [1:0]         resume_sel_o
);
  logic    irq_any;
  logic    held;
  logic    wake;
  resume_e wake_sel;
  resume_e sel_q;

  idle_wake_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .pend_i    (irq_pend_i),
    .en_i      (irq_en_i),
    .irq_any_o (irq_any)
  );

  idle_resume_arb u_arb (
    .dev_rst_i  (dev_rst_i),
    .irq_wake_i (irq_any | held),
    .wdt_to_i   (wdt_timeout_i),
    .wake_o     (wake),
    .sel_o      (wake_sel)
  );

  idle_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrsave_req_i (pwrsave_req_i),
    .irq_any_i     (irq_any),
    .dev_rst_i     (dev_rst_i),
    .wake_i        (wake),
    .wake_sel_i    (wake_sel),
    .held_o        (held),
    .core_clk_en_o (core_clk_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .resume_vld_o  (resume_vld_o),
    .resume_sel_o  (sel_q)
  );

  assign resume_sel_o = sel_q;
  assign lposc_en_o   = wdt_en_i | clkmon_en_i;
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwrsave_req_i,
  input logic [NUM_SRC-1:0] irq_pend_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic               wdt_timeout_i,
  input logic               dev_rst_i,
  input logic               core_clk_en_o,
  input logic               wdt_clr_o,
  input logic               resume_vld_o,
  input logic [1:0]         resume_sel_o
);
  logic idle_now;
  assign idle_now = !core_clk_en_o && !wdt_clr_o;

  AST_ENTRY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en_o && pwrsave_req_i && !dev_rst_i) |=> (!core_clk_en_o && wdt_clr_o)); // R2
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_o |=> (!wdt_clr_o && (!core_clk_en_o || resume_vld_o))); // R2
  AST_VLD_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld_o |-> (core_clk_en_o && $past(!core_clk_en_o))); // R3
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && |(irq_pend_i & irq_en_i) && !dev_rst_i)
      |=> (resume_vld_o && resume_sel_o == 2'd1)); // R4
  AST_WDT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && wdt_timeout_i) |=> resume_vld_o); // R6
  AST_RESET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en_o && dev_rst_i) |=> (resume_vld_o && resume_sel_o == 2'd2)); // R7
  AST_RUN_RESET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en_o && dev_rst_i) |=> core_clk_en_o); // R11
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwrsave_req_i (pwrsave_req_i),
  .irq_pend_i    (irq_pend_i),
  .irq_en_i      (irq_en_i),
  .wdt_timeout_i (wdt_timeout_i),
  .dev_rst_i     (dev_rst_i),
  .core_clk_en_o (core_clk_en_o),
  .wdt_clr_o     (wdt_clr_o),
  .resume_vld_o  (resume_vld_o),
  .resume_sel_o  (resume_sel_o)
);

// File: tb/idle_pwr_ctrl_tb_top.sv
module idle_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pwr = 1'b0;
  logic [NSRC-1:0] pend = '0;
  logic [NSRC-1:0] en = '0;
  logic            wto = 1'b0;
  logic            drst = 1'b0;
  logic            wdt_en = 1'b0;
  logic            cm_en = 1'b0;
  logic            clk_en, clr, lp, vld;
  logic [1:0]      sel;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic       e_clk;
    logic       e_clr;
    logic       e_vld;
    logic [1:0] e_sel;
    logic       e_lp;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_pwr_ctrl #(.NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwrsave_req_i(pwr), .irq_pend_i(pend),
    .irq_en_i(en), .wdt_timeout_i(wto), .dev_rst_i(drst), .wdt_en_i(wdt_en),
    .clkmon_en_i(cm_en), .core_clk_en_o(clk_en), .wdt_clr_o(clr),
    .lposc_en_o(lp), .resume_vld_o(vld), .resume_sel_o(sel)
  );

  // Monitor: pops one expected entry per falling edge
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_cmp++;
      if (clk_en !== e.e_clk || clr !== e.e_clr || vld !== e.e_vld ||
          lp !== e.e_lp || (e.e_vld && sel !== e.e_sel)) begin
        n_bad++;
        $display("FAIL %s: got clk_en=%b clr=%b vld=%b sel=%0d lp=%b, expected clk_en=%b clr=%b vld=%b sel=%0d lp=%b",
                 e.req, clk_en, clr, vld, sel, lp, e.e_clk, e.e_clr, e.e_vld, e.e_sel, e.e_lp);
      end
    end
  end

  task automatic step(input logic p, input logic [NSRC-1:0] pd, input logic [NSRC-1:0] ie,
                      input logic w, input logic d, input logic xclk, input logic xclr,
                      input logic xvld, input logic [1:0] xsel, input string r);
    @(negedge clk); #1;
    pwr = p; pend = pd; en = ie; wto = w; drst = d;
    sb.push_back('{xclk, xclr, xvld, xsel, wdt_en | cm_en, r});
  endtask

  task automatic set_lp(input logic a, input logic b, input string r);
    @(negedge clk); #1;
    pwr = 0; pend = '0; en = '0; wto = 0; drst = 0;
    wdt_en = a; cm_en = b;
    sb.push_back('{1'b1, 1'b0, 1'b0, 2'd0, a | b, r});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (clk_en !== 1'b1 || clr !== 1'b0 || vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got clk_en=%b clr=%b vld=%b, expected 1 0 0", clk_en, clr, vld);
    end
    #1 rst_n = 1'b1;

    // R2/R3/R4: plain entry, idle, enabled interrupt wake
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R2 stays gated");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R3 idle hold");
    step(0, 8'h01, 8'h01, 0, 0, 1, 0, 1, 2'd1, "R4 irq wake");
    step(0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 2'd0, "R3 pulse single");

    // R10: oscillator enable follows its sources
    set_lp(1, 0, "R10 wdt enable");
    // R5/R6: masked pending ignored, watchdog wake
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h02, 8'h01, 0, 0, 0, 0, 0, 2'd0, "R5 masked in entry");
    step(0, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R5 masked in idle");
    step(0, 8'h00, 8'h00, 1, 0, 1, 0, 1, 2'd0, "R6 wdt wake");
    set_lp(0, 1, "R10 monitor enable");

    // R8: interrupt coincident with the request
    step(1, 8'h04, 8'h04, 0, 0, 0, 1, 0, 2'd0, "R8 entry completes");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R8 one idle cycle");
    step(0, 8'h00, 8'h00, 0, 0, 1, 0, 1, 2'd1, "R8 held wake");
    // R8: interrupt arriving during ENTERING
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h08, 8'h08, 0, 0, 0, 0, 0, 2'd0, "R8 latch in entry");
    step(0, 8'h00, 8'h00, 0, 0, 1, 0, 1, 2'd1, "R8 held wake");

    // R7: reset during ENTERING, with a latched interrupt discarded
    step(1, 8'h10, 8'h10, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h00, 8'h00, 0, 1, 1, 0, 1, 2'd2, "R7 reset in entry");
    step(0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 2'd0, "R7 running");
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R7 latch discarded");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R7 latch discarded");
    // R7: reset in idle outranks interrupt and time-out
    step(0, 8'h40, 8'h40, 1, 1, 1, 0, 1, 2'd2, "R7 reset priority");

    // R9: interrupt and time-out together
    step(1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 2'd0, "R2 entry");
    step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 2'd0, "R3 idle hold");
    step(0, 8'h20, 8'h20, 1, 0, 1, 0, 1, 2'd1, "R9 irq over wdt");

    // R11: request with reset while running is ignored
    step(1, 8'h00, 8'h00, 0, 1, 1, 0, 0, 2'd0, "R11 request ignored");
    step(0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 2'd0, "R11 still running");

    @(negedge clk); #1;
    pwr = 0; drst = 0;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule